// File: doc/BRIEF.md
# Masked Queue Descriptor Update Engine

This block applies software update commands to the per-flow descriptors of a receive reordering queue. The descriptors live in a small local store. A command names a descriptor by a 40-bit address and supplies one enable bit for each configurable field, together with new values for those fields. It also carries a flag that wipes the statistics group, a flush request, a status request and a 16-bit command number. Only the fields whose enable is set take the new value. Every other stored field keeps its contents, whatever the command carries for it.

Each command runs through read, merge and write-back steps. When a flush is requested, a single flush pulse follows the write-back. A status record, when requested, closes the command. It reports a result code, the descriptor as it now sits in the store, and a summary of its statistics. A separate event input stands in for the reorder datapath. It advances the statistics of one entry so that the clearing behaviour can be observed.

Top module: `qdu_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, `sts_valid` and `flush_valid` are 0, and every stored descriptor and statistics group reads back as all zeros.
- R2: A descriptor field takes the command's value only when its own enable bit is set; with the enable clear the stored value is kept, whatever the command carries. The enable vector has one bit per field and uses the same field order as the descriptor word.
- R3: A single enable replaces the whole 128-bit packet number at once. The packet-number valid flag is updated only through its own separate enable.
- R4: When a successful command has the clear flag set, the entry's two timestamps, its 64-bit receive bitmap and all eleven counters become zero. Without the flag they are left as they were.
- R5: A successful command with the flush flag set raises `flush_valid` for exactly one cycle, in the cycle after the write-back, with the full 40-bit command address on `flush_addr`. No flush is issued for any other command.
- R6: A command that enables the valid field with a new value of 0 but has no flush flag is rejected with code 3 and changes nothing.
- R7: The packet-number size encodes 0 as 24 bits, 1 as 48 bits and 2 as 128 bits. If its enable is set and the new value is 3, the command is rejected with code 2 and changes nothing. A value of 3 with the enable clear is ignored.
- R8: The entry index is address bits [9:6] and the tag is bits [39:10], which must equal BASE_TAG (default 0). On a tag mismatch the command returns code 1, and neither the descriptor nor its statistics change, even with the clear flag set. A mismatch takes priority over the other error codes.
- R9: A status record is emitted, as a one-cycle `sts_valid` pulse, only when the command asked for one. It echoes the command number, gives the code (0 success) and the descriptor now held at the addressed index. It also gives `sts_stats_any`, the OR of every statistics bit, and `sts_cnt0`, the first counter.
- R10: `cmd_ready` is low from the cycle after acceptance until the command is complete. The status pulse comes 3 cycles after the acceptance edge, or 4 cycles when a flush pulse is issued.
- R11: Each `evt_valid` cycle advances the statistics of entry `evt_idx`: every counter and both timestamps increase by 1, and a 1 is shifted into the receive bitmap. A clear in the same cycle on the same entry takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken on this edge |
| cmd_num | input | 16 | Command number echoed in status |
| cmd_status_req | input | 1 | Status record wanted |
| cmd_addr_lo | input | 32 | Descriptor address bits 31:0 |
| cmd_addr_hi | input | 8 | Descriptor address bits 39:32 |
| cmd_upd | input | 23 | Per-field update enables |
| cmd_cfg | input | 188 | New descriptor field values |
| cmd_clr_stats | input | 1 | Zero the statistics group |
| cmd_flush | input | 1 | Flush the descriptor after update |
| evt_valid | input | 1 | Statistics event |
| evt_idx | input | 4 | Entry index of the event |
| flush_valid | output | 1 | Flush pulse |
| flush_addr | output | 40 | Address being flushed |
| sts_valid | output | 1 | Status record pulse |
| sts_num | output | 16 | Echoed command number |
| sts_code | output | 2 | 0 ok, 1 not found, 2 bad size, 3 valid-clear without flush |
| sts_cfg | output | 188 | Descriptor held at the addressed index |
| sts_stats_any | output | 1 | Any statistics bit non-zero |
| sts_cnt0 | output | 16 | First statistics counter |

## Verification
The hardest case to reach from the ports is a command that must leave the stored state alone: a rejected or mismatched command, or an enable left clear while the command carries a different value. The outcome can only be judged from a later read of the same entry. The stimulus therefore gives every command a distinct, fully populated field pattern and keeps a per-entry model in the bench, and each status record returns the whole stored descriptor. Statistics are first made non-zero through the event input. A clear on a mismatched address and a clear on a hit can then be told apart by the returned counter.

// File: rtl/qdu_pkg.sv
package qdu_pkg;

    localparam int ADDR_W = 40;
    localparam int NUM_W  = 16;
    localparam int QNUM_W = 16;
    localparam int LINK_W = 2;
    localparam int ACLS_W = 2;
    localparam int WIN_W  = 10;
    localparam int SSN_W  = 12;
    localparam int PNSZ_W = 2;
    localparam int PN_W   = 128;
    localparam int TS_W   = 16;
    localparam int MAP_W  = 64;
    localparam int CNT_W  = 16;
    localparam int N_CNT  = 11;

    localparam logic [PNSZ_W-1:0] PNSZ_ILLEGAL = 2'd3;

    // Descriptor configuration word, one entry per updatable field.
    typedef struct packed {
        logic [QNUM_W-1:0] qnum;
        logic              vld;
        logic [LINK_W-1:0] link_cnt;
        logic              dup_off;
        logic              soft_reo;
        logic [ACLS_W-1:0] acls;
        logic              bar;
        logic              rty;
        logic              chk2k;
        logic              oor;
        logic [WIN_W-1:0]  win;
        logic              pn_chk;
        logic              pn_even;
        logic              pn_odd;
        logic              pn_en;
        logic              ign_agg;
        logic [PNSZ_W-1:0] pn_sz;
        logic              ssn_vld;
        logic [SSN_W-1:0]  ssn;
        logic              seq_err;
        logic              pn_err;
        logic              pn_vld;
        logic [PN_W-1:0]   pn;
    } cfg_t;

    // One enable per field of cfg_t, same order.
    typedef struct packed {
        logic qnum, vld, link_cnt, dup_off, soft_reo, acls, bar, rty, chk2k, oor, win;
        logic pn_chk, pn_even, pn_odd, pn_en, ign_agg, pn_sz, ssn_vld, ssn;
        logic seq_err, pn_err, pn_vld, pn;
    } upd_t;

    typedef struct packed {
        logic [TS_W-1:0]             ts_enq;
        logic [TS_W-1:0]             ts_deq;
        logic [MAP_W-1:0]            rx_map;
        logic [N_CNT-1:0][CNT_W-1:0] cnt;
    } stat_t;

    typedef enum logic [1:0] {
        ST_OK          = 2'd0,
        ST_MISS        = 2'd1,
        ST_BAD_PNSZ    = 2'd2,
        ST_VLD_NOFLUSH = 2'd3
    } code_e;

    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_WRITE, S_FLUSH, S_REPORT
    } state_e;

    localparam int CFG_W = $bits(cfg_t);
    localparam int UPD_W = $bits(upd_t);

    // Widen each enable bit to the width of its field.
    function automatic cfg_t expand_mask(upd_t u);
        cfg_t m;
        m.qnum     = {QNUM_W{u.qnum}};
        m.vld      = u.vld;
        m.link_cnt = {LINK_W{u.link_cnt}};
        m.dup_off  = u.dup_off;
        m.soft_reo = u.soft_reo;
        m.acls     = {ACLS_W{u.acls}};
        m.bar      = u.bar;
        m.rty      = u.rty;
        m.chk2k    = u.chk2k;
        m.oor      = u.oor;
        m.win      = {WIN_W{u.win}};
        m.pn_chk   = u.pn_chk;
        m.pn_even  = u.pn_even;
        m.pn_odd   = u.pn_odd;
        m.pn_en    = u.pn_en;
        m.ign_agg  = u.ign_agg;
        m.pn_sz    = {PNSZ_W{u.pn_sz}};
        m.ssn_vld  = u.ssn_vld;
        m.ssn      = {SSN_W{u.ssn}};
        m.seq_err  = u.seq_err;
        m.pn_err   = u.pn_err;
        m.pn_vld   = u.pn_vld;
        m.pn       = {PN_W{u.pn}};
        return m;
    endfunction

    function automatic stat_t stat_bump(stat_t s);
        stat_t r;
        r        = s;
        r.ts_enq = s.ts_enq + TS_W'(1);
        r.ts_deq = s.ts_deq + TS_W'(1);
        r.rx_map = {s.rx_map[MAP_W-2:0], 1'b1};
        for (int k = 0; k < N_CNT; k++) begin
            r.cnt[k] = s.cnt[k] + CNT_W'(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/qdu_merge.sv
module qdu_merge
    import qdu_pkg::*;
(
    input  cfg_t  old_cfg,
    input  cfg_t  new_cfg,
    input  upd_t  upd,
    input  logic  hit,
    input  logic  flush,
    output cfg_t  merged,
    output code_e code
);
    cfg_t mask;

    always_comb begin
        mask   = expand_mask(upd);
        merged = cfg_t'((old_cfg & ~mask) | (new_cfg & mask));
        if (!hit)
            code = ST_MISS;
        else if (upd.pn_sz && new_cfg.pn_sz == PNSZ_ILLEGAL)
            code = ST_BAD_PNSZ;
        else if (upd.vld && !new_cfg.vld && !flush)
            code = ST_VLD_NOFLUSH;
        else
            code = ST_OK;
    end
endmodule

// File: rtl/qdu_store.sv
module qdu_store
    import qdu_pkg::*;
#(
    parameter int N_ENTRY = 16,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output cfg_t             rd_cfg,
    output stat_t            rd_stat,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  cfg_t             wr_cfg,
    input  logic             clr_en,
    input  logic             evt_valid,
    input  logic [IDX_W-1:0] evt_idx
);
    cfg_t  cfg_arr  [N_ENTRY];
    stat_t stat_arr [N_ENTRY];

    for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
        cfg_t  cfg_r;
        stat_t stat_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_r  <= '0;
                stat_r <= '0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(i))
                    cfg_r <= wr_cfg;
                if (clr_en && wr_idx == IDX_W'(i))
                    stat_r <= '0;
                else if (evt_valid && evt_idx == IDX_W'(i))
                    stat_r <= stat_bump(stat_r);
            end
        end
        assign cfg_arr[i]  = cfg_r;
        assign stat_arr[i] = stat_r;
    end

    assign rd_cfg  = cfg_arr[rd_idx];
    assign rd_stat = stat_arr[rd_idx];

    // A rejected size never reaches the store.
    assert_pnsz_legal_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_cfg.pn_sz != PNSZ_ILLEGAL);

    // A clear only comes with a write-back of the same command.
    assert_clear_with_write_R4: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> wr_en);
endmodule

// File: rtl/qdu_engine.sv
module qdu_engine
    import qdu_pkg::*;
#(
    parameter int          N_ENTRY    = 16,
    parameter int          DESC_BYTES = 64,
    parameter int unsigned BASE_TAG   = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [NUM_W-1:0]             cmd_num,
    input  logic                         cmd_status_req,
    input  logic [31:0]                  cmd_addr_lo,
    input  logic [ADDR_W-33:0]           cmd_addr_hi,
    input  logic [UPD_W-1:0]             cmd_upd,
    input  logic [CFG_W-1:0]             cmd_cfg,
    input  logic                         cmd_clr_stats,
    input  logic                         cmd_flush,
    input  logic                         evt_valid,
    input  logic [$clog2(N_ENTRY)-1:0]   evt_idx,
    output logic                         flush_valid,
    output logic [ADDR_W-1:0]            flush_addr,
    output logic                         sts_valid,
    output logic [NUM_W-1:0]             sts_num,
    output logic [1:0]                   sts_code,
    output logic [CFG_W-1:0]             sts_cfg,
    output logic                         sts_stats_any,
    output logic [CNT_W-1:0]             sts_cnt0
);
    localparam int IDX_W   = $clog2(N_ENTRY);
    localparam int OFS_W   = $clog2(DESC_BYTES);
    localparam int TAG_LSB = OFS_W + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;

    state_e            state;
    logic [NUM_W-1:0]  c_num;
    logic              c_req, c_clr, c_flush;
    logic [ADDR_W-1:0] c_addr;
    upd_t              c_upd;
    cfg_t              c_cfg, old_cfg, merged;
    code_e             code, code_q;
    logic              hit, st_wr_en;
    logic [IDX_W-1:0]  idx;
    cfg_t              rd_cfg;
    stat_t             rd_stat;

    assign idx = c_addr[TAG_LSB-1:OFS_W];
    assign hit = c_addr[ADDR_W-1:TAG_LSB] == TAG_W'(BASE_TAG);

    qdu_merge u_merge (
        .old_cfg (old_cfg),
        .new_cfg (c_cfg),
        .upd     (c_upd),
        .hit     (hit),
        .flush   (c_flush),
        .merged  (merged),
        .code    (code)
    );

    assign st_wr_en = (state == S_WRITE) && (code == ST_OK);

    qdu_store #(.N_ENTRY(N_ENTRY)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (idx),
        .rd_cfg    (rd_cfg),
        .rd_stat   (rd_stat),
        .wr_en     (st_wr_en),
        .wr_idx    (idx),
        .wr_cfg    (merged),
        .clr_en    (st_wr_en && c_clr),
        .evt_valid (evt_valid),
        .evt_idx   (evt_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            c_num   <= '0;
            c_req   <= 1'b0;
            c_clr   <= 1'b0;
            c_flush <= 1'b0;
            c_addr  <= '0;
            c_upd   <= '0;
            c_cfg   <= '0;
            old_cfg <= '0;
            code_q  <= ST_OK;
        end else begin
            unique case (state)
                S_IDLE: if (cmd_valid) begin
                    c_num   <= cmd_num;
                    c_req   <= cmd_status_req;
                    c_clr   <= cmd_clr_stats;
                    c_flush <= cmd_flush;
                    c_addr  <= {cmd_addr_hi, cmd_addr_lo};
                    c_upd   <= upd_t'(cmd_upd);
                    c_cfg   <= cfg_t'(cmd_cfg);
                    state   <= S_READ;
                end
                S_READ: begin
                    old_cfg <= rd_cfg;
                    state   <= S_WRITE;
                end
                S_WRITE: begin
                    code_q <= code;
                    state  <= (c_flush && code == ST_OK) ? S_FLUSH : S_REPORT;
                end
                S_FLUSH:  state <= S_REPORT;
                S_REPORT: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    assign cmd_ready     = (state == S_IDLE);
    assign flush_valid   = (state == S_FLUSH);
    assign flush_addr    = c_addr;
    assign sts_valid     = (state == S_REPORT) && c_req;
    assign sts_num       = c_num;
    assign sts_code      = code_q;
    assign sts_cfg       = rd_cfg;
    assign sts_stats_any = |rd_stat;
    assign sts_cnt0      = rd_stat.cnt[0];

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_ready);

    assert_flush_after_write_R5: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> $past(st_wr_en));

    assert_flush_single_R5: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> !flush_valid);

    assert_flush_only_ok_R8: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> sts_code == ST_OK);

    assert_status_closes_R9: assert property (@(posedge clk) disable iff (rst)
        sts_valid |=> cmd_ready);
endmodule

// File: tb/tb_qdu_engine.sv
module tb_qdu_engine;
    import qdu_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              cmd_valid = 1'b0, cmd_ready;
    logic [NUM_W-1:0]  cmd_num = '0;
    logic              cmd_status_req = 1'b0;
    logic [31:0]       cmd_addr_lo = '0;
    logic [7:0]        cmd_addr_hi = '0;
    logic [UPD_W-1:0]  cmd_upd = '0;
    logic [CFG_W-1:0]  cmd_cfg = '0;
    logic              cmd_clr_stats = 1'b0, cmd_flush = 1'b0;
    logic              evt_valid = 1'b0;
    logic [3:0]        evt_idx = '0;
    logic              flush_valid, sts_valid, sts_stats_any;
    logic [ADDR_W-1:0] flush_addr;
    logic [NUM_W-1:0]  sts_num;
    logic [1:0]        sts_code;
    logic [CFG_W-1:0]  sts_cfg;
    logic [CNT_W-1:0]  sts_cnt0;

    qdu_engine dut (.*);

    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    localparam logic [2:0] MK_ALL = 0, MK_NONE = 1, MK_QNUM = 2, MK_PN = 3,
                           MK_PNVLD = 4, MK_VLD = 5, MK_NOPNSZ = 6;

    function automatic upd_t mk_upd(logic [2:0] mk);
        upd_t u = '0;
        case (mk)
            MK_ALL:    u = '1;
            MK_QNUM:   u.qnum = 1'b1;
            MK_PN:     u.pn = 1'b1;
            MK_PNVLD:  u.pn_vld = 1'b1;
            MK_VLD:    u.vld = 1'b1;
            MK_NOPNSZ: begin u = '1; u.pn_sz = 1'b0; end
            default:   u = '0;
        endcase
        return u;
    endfunction

    function automatic cfg_t mk_cfg(logic [31:0] s, logic v, logic [1:0] sz);
        logic [191:0] r;
        cfg_t c;
        r = {s, ~s, s ^ 32'h5A5A_C3C3, {s[15:0], s[31:16]}, s + 32'h1357_9BDF, ~s ^ 32'h0F0F_0F0F};
        c = cfg_t'(r[CFG_W-1:0]);
        c.vld = v;
        c.pn_sz = sz;
        return c;
    endfunction

    // Independent field-by-field model of a masked update.
    function automatic cfg_t model_merge(cfg_t o, cfg_t n, upd_t u);
        cfg_t r = o;
        if (u.qnum) r.qnum = n.qnum;
        if (u.vld) r.vld = n.vld;
        if (u.link_cnt) r.link_cnt = n.link_cnt;
        if (u.dup_off) r.dup_off = n.dup_off;
        if (u.soft_reo) r.soft_reo = n.soft_reo;
        if (u.acls) r.acls = n.acls;
        if (u.bar) r.bar = n.bar;
        if (u.rty) r.rty = n.rty;
        if (u.chk2k) r.chk2k = n.chk2k;
        if (u.oor) r.oor = n.oor;
        if (u.win) r.win = n.win;
        if (u.pn_chk) r.pn_chk = n.pn_chk;
        if (u.pn_even) r.pn_even = n.pn_even;
        if (u.pn_odd) r.pn_odd = n.pn_odd;
        if (u.pn_en) r.pn_en = n.pn_en;
        if (u.ign_agg) r.ign_agg = n.ign_agg;
        if (u.pn_sz) r.pn_sz = n.pn_sz;
        if (u.ssn_vld) r.ssn_vld = n.ssn_vld;
        if (u.ssn) r.ssn = n.ssn;
        if (u.seq_err) r.seq_err = n.seq_err;
        if (u.pn_err) r.pn_err = n.pn_err;
        if (u.pn_vld) r.pn_vld = n.pn_vld;
        if (u.pn) r.pn = n.pn;
        return r;
    endfunction

    typedef struct packed {
        logic [3:0]  idx;
        logic [2:0]  mk;
        logic [31:0] seed;
        logic        vld;
        logic [1:0]  pnsz;
        logic        flush;
        logic        badtag;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  MK_ALL,    32'hA1B2_C3D4, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0},
        '{4'd1,  MK_QNUM,   32'h1111_2222, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0},
        '{4'd1,  MK_PN,     32'hDEAD_BEEF, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0},
        '{4'd1,  MK_PNVLD,  32'h7777_0000, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0},
        '{4'd2,  MK_ALL,    32'h0BAD_512E, 1'b1, 2'd3, 1'b0, 1'b0, 2'd2},
        '{4'd1,  MK_VLD,    32'h5555_AAAA, 1'b0, 2'd0, 1'b0, 1'b0, 2'd3},
        '{4'd1,  MK_VLD,    32'h5555_AAAA, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0},
        '{4'd3,  MK_ALL,    32'h3333_4444, 1'b1, 2'd1, 1'b0, 1'b1, 2'd1},
        '{4'd2,  MK_NOPNSZ, 32'h2468_ACE0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0},
        '{4'd15, MK_ALL,    32'hF00D_CAFE, 1'b1, 2'd1, 1'b1, 1'b0, 2'd0},
        '{4'd0,  MK_NONE,   32'h9999_8888, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0},
        '{4'd0,  MK_ALL,    32'h0123_4567, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0},
        '{4'd2,  MK_ALL,    32'hCCCC_1234, 1'b0, 2'd3, 1'b0, 1'b1, 2'd1}
    };

    cfg_t model [16];

    // Captured results of the last command.
    bit                r_busy, r_flush, r_sts;
    int                r_flush_at, r_sts_at;
    logic [ADDR_W-1:0] r_faddr;
    logic [NUM_W-1:0]  r_num;
    logic [1:0]        r_code;
    cfg_t              r_cfg;
    logic              r_any;
    logic [CNT_W-1:0]  r_cnt0;

    function automatic logic [ADDR_W-1:0] mk_addr(logic [3:0] idx, logic bad);
        return {bad, 29'd0, idx, 6'h2A};
    endfunction

    task automatic run_cmd(logic [15:0] num, logic req, logic [ADDR_W-1:0] a, upd_t u,
                           cfg_t c, logic clr, logic fl);
        @(negedge clk);
        cmd_num = num; cmd_status_req = req; cmd_addr_lo = a[31:0]; cmd_addr_hi = a[39:32];
        cmd_upd = u; cmd_cfg = c; cmd_clr_stats = clr; cmd_flush = fl; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        r_busy = !cmd_ready; r_flush = 0; r_sts = 0; r_flush_at = 0; r_sts_at = 0;
        for (int n = 1; n <= 8; n++) begin
            if (flush_valid) begin r_flush = 1; r_flush_at = n; r_faddr = flush_addr; end
            if (sts_valid) begin
                r_sts = 1; r_sts_at = n; r_num = sts_num; r_code = sts_code;
                r_cfg = cfg_t'(sts_cfg); r_any = sts_stats_any; r_cnt0 = sts_cnt0;
            end
            @(negedge clk);
        end
    endtask

    task automatic bump(logic [3:0] idx, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_valid = 1'b1; evt_idx = idx;
        end
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", 256'(cmd_ready), 1);
        chk(sts_valid == 1'b0 && flush_valid == 1'b0, "R1", "no pulses", 256'({sts_valid, flush_valid}), 0);
        run_cmd(16'h00F0, 1'b1, mk_addr(4'd5, 1'b0), mk_upd(MK_NONE), '0, 1'b0, 1'b0);
        chk(r_cfg == '0, "R1", "reset descriptor", 256'(r_cfg), 0);
        chk(r_any == 1'b0, "R1", "reset stats", 256'(r_any), 0);

        // Table walk: R2 R3 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            vec_t t = VEC[v];
            upd_t u = mk_upd(t.mk);
            cfg_t c = mk_cfg(t.seed, t.vld, t.pnsz);
            logic [ADDR_W-1:0] a = mk_addr(t.idx, t.badtag);
            bit fl_exp = t.flush && t.exp == 2'd0;
            run_cmd(16'h0100 + 16'(v), 1'b1, a, u, c, 1'b0, t.flush);
            if (t.exp == 2'd0) model[t.idx] = model_merge(model[t.idx], c, u);
            chk(r_sts && r_num == 16'h0100 + 16'(v), "R9", "status number", 256'(r_num), 256'(16'h0100 + 16'(v)));
            chk(r_code == t.exp, t.exp == 1 ? "R8" : t.exp == 2 ? "R7" : t.exp == 3 ? "R6" : "R2",
                "status code", 256'(r_code), 256'(t.exp));
            chk(r_cfg == model[t.idx], t.mk == MK_PN || t.mk == MK_PNVLD ? "R3" : "R2",
                "stored descriptor", 256'(r_cfg), 256'(model[t.idx]));
            chk(r_flush == fl_exp, "R5", "flush presence", 256'(r_flush), 256'(fl_exp));
            if (fl_exp) begin
                chk(r_flush_at == 3 && r_faddr == a, "R5", "flush cycle/address",
                    256'({r_flush_at, r_faddr}), 256'({32'd3, a}));
            end
            chk(r_busy && r_sts_at == (fl_exp ? 4 : 3), "R10", "busy and status latency",
                256'({r_busy, r_sts_at}), 256'({1'b1, fl_exp ? 32'd4 : 32'd3}));
        end

        // R11: events advance statistics of the indexed entry
        bump(4'd2, 3);
        run_cmd(16'h0200, 1'b1, mk_addr(4'd2, 1'b0), mk_upd(MK_NONE), '0, 1'b0, 1'b0);
        chk(r_cnt0 == 16'd3 && r_any, "R11", "counter after 3 events", 256'(r_cnt0), 3);
        chk(r_cfg == model[2], "R11", "descriptor untouched by events", 256'(r_cfg), 256'(model[2]));

        // R4: clear on a hit wipes the group, descriptor kept
        run_cmd(16'h0201, 1'b1, mk_addr(4'd2, 1'b0), mk_upd(MK_NONE), '1, 1'b1, 1'b0);
        chk(r_any == 1'b0, "R4", "stats cleared", 256'(r_any), 0);
        chk(r_cfg == model[2], "R4", "descriptor kept on clear", 256'(r_cfg), 256'(model[2]));

        // R8: clear on a tag mismatch leaves statistics alone
        bump(4'd4, 1);
        run_cmd(16'h0202, 1'b1, mk_addr(4'd4, 1'b1), mk_upd(MK_NONE), '0, 1'b1, 1'b0);
        chk(r_code == 2'd1 && r_cnt0 == 16'd1, "R8", "miss keeps stats",
            256'({r_code, r_cnt0}), 256'({2'd1, 16'd1}));

        // R9: no status record when not requested, update still applied
        begin
            cfg_t c = mk_cfg(32'h6543_2100, 1'b0, 2'd0);
            upd_t u = mk_upd(MK_QNUM);
            run_cmd(16'h0203, 1'b0, mk_addr(4'd6, 1'b0), u, c, 1'b0, 1'b0);
            model[6] = model_merge(model[6], c, u);
            chk(r_sts == 1'b0, "R9", "no status without request", 256'(r_sts), 0);
            run_cmd(16'h0204, 1'b1, mk_addr(4'd6, 1'b0), mk_upd(MK_NONE), '0, 1'b0, 1'b0);
            chk(r_cfg == model[6], "R9", "silent update visible", 256'(r_cfg), 256'(model[6]));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule